// File: doc/BRIEF.md
# Subcode Q Channel Capture and Serial Readout

This block collects the Q-channel subcode carried one bit per frame. A subcode block begins with the two sync patterns S0 and S1. These arrive as single-cycle flags on `sync0` and `sync1`. After them come 96 Q bits, each marked by a one-cycle strobe. The first 80 bits are the Q payload and the last 16 are a check word. When the last bit arrives, the block computes a CRC over the payload and compares it with the check word. It also confirms that S1 directly followed S0. If both tests pass, it copies the payload into a readout buffer and pulls the active-low ready output low.

A host reads the buffer over a three-wire command port, sampled in the block's clock domain. The host holds the latch line high and shifts in an 8-bit command. When the latch line falls, the command takes effect. If the low nibble selects the subcode-ready status, the block drives the data line for as long as the latch stays low. The first bit driven is the current ready level. Each rising host clock then advances the output through Q1 to Q80. The buffer changes only when a block is validated, so a new block that is still accumulating cannot disturb a read.

Top module: `subq_capture`

## Requirements
- R1: The Q bits of a block are assembled MSB first. The first bit after the syncs becomes Q1 and the 80th becomes Q80. Bits 81 to 96 form the check word, first bit most significant.
- R2: The CRC uses x^16+x^12+x^5+1, a zero start value and MSB-first processing over Q1..Q80. It passes when it equals the bitwise inverse of the check word. `crc_ok` updates on the cycle after the 96th strobe (1 = pass) and then holds until the next block's 96th strobe.
- R3: `ready_n` falls only after a 96th strobe where the CRC passed and S1 was seen after S0 with no Q strobe between them. A failing CRC or a missing S1 leaves it high.
- R4: `ready_n` returns high on the cycle after the `sync0` flag that starts a new block.
- R5: The readout buffer is loaded only from a validated block. Failed blocks, blocks cut short by a new `sync0`, and blocks still accumulating leave it unchanged, so a read in progress is not disturbed.
- R6: While `hlat` is high, each rising `hck` shifts `hsdi` into an 8-bit command, D0 first. The falling edge of `hlat` applies it. Only D3..D0 are decoded, and the value 4'b0010 selects subcode readout; D7..D4 are ignored.
- R7: After a subcode-readout command, `sdo_oe` stays high while `hlat` is low. `sdo` first shows the `ready_n` level. Each rising `hck` advances it to Q1, then Q2, and so on up to Q80; after Q80 it shows 0. `sdo_oe` drops one cycle after `hlat` rises.
- R8: A command with any other low nibble leaves `sdo_oe` low and `sdo` at 0.
- R9: Q strobes that arrive after the 96th bit and before the next `sync0` change neither `ready_n`, `crc_ok` nor the buffer.
- R10: After reset, `ready_n` is 1, `crc_ok` is 0, `sdo_oe` is 0 and the buffer holds all zeros.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| sync0 | input | 1 | One-cycle flag: S0 pattern seen, block starts |
| sync1 | input | 1 | One-cycle flag: S1 pattern seen |
| q_stb | input | 1 | One-cycle strobe marking a valid Q bit |
| q_bit | input | 1 | Q-channel bit of the current frame |
| hck | input | 1 | Host port shift clock (sampled) |
| hlat | input | 1 | Host port latch line (sampled) |
| hsdi | input | 1 | Host port serial command data |
| sdo | output | 1 | Host port serial read data |
| sdo_oe | output | 1 | Drive enable for the host data line |
| ready_n | output | 1 | Low when a validated Q block is ready to read |
| crc_ok | output | 1 | High when the last complete block passed its CRC |

## Verification
The assertions check, on every cycle, the rules that order events. Ready may fall only with a passing CRC and may rise only after a block start. The buffer and the CRC flag stay stable except on their own update events. The bit count never passes 96, and the data line is driven only while the latch is low. The bench scenarios show what the assertions cannot. They check that the payload comes out bit-exact and in the right order, that the bench's own CRC agrees with the block's verdict, and that a read stays intact while a new block accumulates. They also cover aborted and over-long blocks, and the handling of foreign command codes and of ignored high command bits.

// File: rtl/subq_pkg.sv
package subq_pkg;
  localparam int QB   = 80;
  localparam int CW   = 16;
  localparam int TB   = QB + CW;
  localparam int CMDW = 8;
  localparam int CNTW = $clog2(TB + 1);
  localparam int IDXW = $clog2(QB + 2);
  localparam logic [CW-1:0] CRC_POLY = 16'h1021;
  localparam logic [3:0]    RD_CODE  = 4'b0010;

  // MSB-first CRC over the Q payload, zero start value
  function automatic logic [CW-1:0] crc_q(input logic [QB-1:0] d);
    logic [CW-1:0] c;
    logic fb;
    c = '0;
    for (int i = QB - 1; i >= 0; i--) begin
      fb = c[CW-1] ^ d[i];
      c  = {c[CW-2:0], 1'b0};
      if (fb) c = c ^ CRC_POLY;
    end
    return c;
  endfunction

  function automatic logic check_pass(input logic [TB-1:0] frame);
    return crc_q(frame[TB-1:CW]) == ~frame[CW-1:0];
  endfunction
endpackage

// File: rtl/subq_collect.sv
module subq_collect
  import subq_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            sync0,
  input  logic            sync1,
  input  logic            q_stb,
  input  logic            q_bit,
  output logic [TB-1:0]   frame_nx,
  output logic            blk_done,
  output logic            sync_ok,
  output logic [CNTW-1:0] bit_cnt
);
  logic [TB-1:0] sr;
  logic          active;
  logic          s1_seen;
  logic          take;

  assign frame_nx = {sr[TB-2:0], q_bit};
  assign take     = q_stb && !sync0 && !sync1 && active;
  assign blk_done = take && (bit_cnt == CNTW'(TB - 1));
  assign sync_ok  = s1_seen;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr      <= '0;
      active  <= 1'b0;
      s1_seen <= 1'b0;
      bit_cnt <= '0;
    end else if (sync0) begin
      active  <= 1'b1;
      s1_seen <= 1'b0;
      bit_cnt <= '0;
    end else if (sync1) begin
      if (active && bit_cnt == '0) s1_seen <= 1'b1;
    end else if (take) begin
      sr      <= frame_nx;
      bit_cnt <= bit_cnt + 1'b1;
      if (blk_done) active <= 1'b0;
    end
  end
endmodule

// File: rtl/subq_judge.sv
module subq_judge
  import subq_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          blk_start,
  input  logic          blk_done,
  input  logic          sync_ok,
  input  logic [TB-1:0] frame_nx,
  output logic          val_evt,
  output logic          ready_n,
  output logic          crc_ok,
  output logic [QB-1:0] rbuf
);
  logic crc_pass;

  assign crc_pass = check_pass(frame_nx);
  assign val_evt  = blk_done && crc_pass && sync_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ready_n <= 1'b1;
      crc_ok  <= 1'b0;
      rbuf    <= '0;
    end else begin
      if (blk_done) crc_ok <= crc_pass;
      if (blk_start) begin
        ready_n <= 1'b1;
      end else if (val_evt) begin
        ready_n <= 1'b0;
        rbuf    <= frame_nx[TB-1:CW];
      end
    end
  end
endmodule

// File: rtl/subq_host_port.sv
module subq_host_port
  import subq_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          hck,
  input  logic          hlat,
  input  logic          hsdi,
  input  logic          ready_n,
  input  logic [QB-1:0] rbuf,
  output logic          sdo,
  output logic          sdo_oe
);
  logic            hck_q, hlat_q;
  logic            ck_rise, lat_fall, lat_rise;
  logic [CMDW-1:0] cmd;
  logic [IDXW-1:0] idx;
  logic            rd_on;
  logic            bit_sel;

  assign ck_rise  = hck && !hck_q;
  assign lat_fall = !hlat && hlat_q;
  assign lat_rise = hlat && !hlat_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hck_q  <= 1'b0;
      hlat_q <= 1'b1;
      cmd    <= '0;
      idx    <= '0;
      rd_on  <= 1'b0;
    end else begin
      hck_q  <= hck;
      hlat_q <= hlat;
      if (hlat && ck_rise) cmd <= {hsdi, cmd[CMDW-1:1]};
      if (lat_fall) begin
        rd_on <= (cmd[3:0] == RD_CODE);
        idx   <= '0;
      end else if (lat_rise) begin
        rd_on <= 1'b0;
      end else if (rd_on && ck_rise && idx <= IDXW'(QB)) begin
        idx <= idx + 1'b1;
      end
    end
  end

  always_comb begin
    bit_sel = 1'b0;
    if (idx == '0)             bit_sel = ready_n;
    else if (idx <= IDXW'(QB)) bit_sel = rbuf[QB - int'(idx)];
  end

  assign sdo_oe = rd_on;
  assign sdo    = rd_on && bit_sel;
endmodule

// File: rtl/subq_capture.sv
module subq_capture
  import subq_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic sync0,
  input  logic sync1,
  input  logic q_stb,
  input  logic q_bit,
  input  logic hck,
  input  logic hlat,
  input  logic hsdi,
  output logic sdo,
  output logic sdo_oe,
  output logic ready_n,
  output logic crc_ok
);
  logic [TB-1:0]   frame_nx;
  logic            blk_done;
  logic            sync_ok;
  logic [CNTW-1:0] bit_cnt;
  logic            val_evt;
  logic [QB-1:0]   rbuf;

  subq_collect u_collect (
    .clk(clk), .rst_n(rst_n), .sync0(sync0), .sync1(sync1),
    .q_stb(q_stb), .q_bit(q_bit), .frame_nx(frame_nx),
    .blk_done(blk_done), .sync_ok(sync_ok), .bit_cnt(bit_cnt)
  );

  subq_judge u_judge (
    .clk(clk), .rst_n(rst_n), .blk_start(sync0), .blk_done(blk_done),
    .sync_ok(sync_ok), .frame_nx(frame_nx), .val_evt(val_evt),
    .ready_n(ready_n), .crc_ok(crc_ok), .rbuf(rbuf)
  );

  subq_host_port u_host (
    .clk(clk), .rst_n(rst_n), .hck(hck), .hlat(hlat), .hsdi(hsdi),
    .ready_n(ready_n), .rbuf(rbuf), .sdo(sdo), .sdo_oe(sdo_oe)
  );
endmodule

// File: rtl/subq_capture_sva.sv
module subq_capture_sva
  import subq_pkg::*;
(
  input logic            clk,
  input logic            rst_n,
  input logic            sync0,
  input logic            hlat,
  input logic            ready_n,
  input logic            crc_ok,
  input logic            sdo_oe,
  input logic            val_evt,
  input logic            blk_done,
  input logic [CNTW-1:0] bit_cnt,
  input logic [QB-1:0]   rbuf
);
  assert_ready_needs_crc_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ready_n) |-> crc_ok);

  assert_valid_lowers_ready_R3: assert property (@(posedge clk) disable iff (!rst_n)
    val_evt |=> !ready_n);

  assert_ready_rise_on_start_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ready_n) |-> $past(sync0));

  assert_buf_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !val_evt |=> $stable(rbuf));

  assert_crc_flag_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !blk_done |=> $stable(crc_ok));

  assert_cnt_bound_R9: assert property (@(posedge clk) disable iff (!rst_n)
    bit_cnt <= CNTW'(TB));

  assert_drive_latch_low_R7: assert property (@(posedge clk) disable iff (!rst_n)
    sdo_oe |-> $past(!hlat));
endmodule

bind subq_capture subq_capture_sva u_sva (
  .clk(clk), .rst_n(rst_n), .sync0(sync0), .hlat(hlat), .ready_n(ready_n),
  .crc_ok(crc_ok), .sdo_oe(sdo_oe), .val_evt(val_evt), .blk_done(blk_done),
  .bit_cnt(bit_cnt), .rbuf(rbuf)
);

// File: tb/tb_subq_capture.sv
module tb_subq_capture;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sync0 = 0, sync1 = 0, q_stb = 0, q_bit = 0;
  logic hck = 0, hlat = 1, hsdi = 0;
  logic sdo, sdo_oe, ready_n, crc_ok;

  int n_chk = 0, n_fail = 0;
  bit finished = 0;
  logic [79:0] last_good = '0;

  always #5 clk = ~clk;

  subq_capture dut (
    .clk(clk), .rst_n(rst_n), .sync0(sync0), .sync1(sync1), .q_stb(q_stb),
    .q_bit(q_bit), .hck(hck), .hlat(hlat), .hsdi(hsdi), .sdo(sdo),
    .sdo_oe(sdo_oe), .ready_n(ready_n), .crc_ok(crc_ok)
  );

  // {payload, corrupt check word, omit S1}
  localparam logic [81:0] VECS [6] = '{
    {80'h4102_0000_0100_0203_0045, 1'b0, 1'b0},
    {80'h0000_0000_0000_0000_0000, 1'b0, 1'b0},
    {80'h0123_4567_89AB_CDEF_1357, 1'b1, 1'b0},
    {80'hFFFF_FFFF_FFFF_FFFF_FFFF, 1'b0, 1'b0},
    {80'hAAAA_5555_F00F_0FF0_C3C3, 1'b0, 1'b1},
    {80'h8000_0000_0000_0000_0001, 1'b0, 1'b0}
  };

  // polynomial long division of payload * x^16
  function automatic logic [15:0] ref_crc(input logic [79:0] d);
    logic [95:0] m;
    m = {d, 16'h0000};
    for (int i = 95; i >= 16; i--)
      if (m[i]) m[i -: 17] = m[i -: 17] ^ 17'h11021;
    return m[15:0];
  endfunction

  task automatic chk(input bit ok, input string req, input logic [79:0] act,
                     input logic [79:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic push_bits(input logic [95:0] bits, input int nb);
    for (int i = 0; i < nb; i++) begin
      q_bit = bits[95 - i]; q_stb = 1; tick();
      q_stb = 0; tick();
    end
  endtask

  task automatic start_block(input bit nos1);
    sync0 = 1; tick(); sync0 = 0; tick();
    if (!nos1) begin sync1 = 1; tick(); sync1 = 0; tick(); end
  endtask

  task automatic send_block(input logic [79:0] d, input bit corrupt, input bit nos1);
    logic [15:0] chkw;
    chkw = ~ref_crc(d);
    if (corrupt) chkw[0] = ~chkw[0];
    start_block(nos1);
    push_bits({d, chkw}, 96);
  endtask

  task automatic host_cmd(input logic [7:0] cmd);
    hlat = 1; tick();
    for (int i = 0; i < 8; i++) begin
      hsdi = cmd[i]; hck = 1; tick();
      hck = 0; tick();
    end
    hlat = 0; tick();
  endtask

  task automatic host_read(input logic [7:0] cmd, input logic exp_stat,
                           input logic [79:0] exp, input bit inject, input string req);
    logic [79:0] got;
    logic [79:0] junk;
    host_cmd(cmd);
    chk(sdo_oe == 1'b1 && sdo == exp_stat, {req, " status bit"},
        {78'd0, sdo_oe, sdo}, {78'd0, 1'b1, exp_stat});
    for (int k = 1; k <= 80; k++) begin
      hck = 1; tick(); hck = 0;
      got[80 - k] = sdo;
      tick();
      if (inject && k == 40) begin
        junk = 80'hDEAD_BEEF_0BAD_F00D_1234;
        start_block(1'b0);
        push_bits({junk, 16'hFFFF}, 30);
      end
    end
    chk(got == exp, {req, " Q1..Q80"}, got, exp);
    hck = 1; tick(); hck = 0; tick();
    chk(sdo == 1'b0, {req, " R7 zero after Q80"}, {79'd0, sdo}, 80'd0);
    hlat = 1; tick(); tick();
    chk(sdo_oe == 1'b0, {req, " R7 release"}, {79'd0, sdo_oe}, 80'd0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) tick();
    chk(ready_n == 1 && crc_ok == 0 && sdo_oe == 0, "R10 reset outputs",
        {77'd0, ready_n, crc_ok, sdo_oe}, {77'd0, 3'b100});
    rst_n = 1; tick();
    host_read(8'h02, 1'b1, 80'd0, 0, "R10 buffer zero");

    // table of vectors
    for (int v = 0; v < 6; v++) begin
      logic [79:0] d;
      bit cor, nos1, good;
      {d, cor, nos1} = VECS[v];
      good = !cor && !nos1;
      send_block(d, cor, nos1);
      chk(crc_ok == !cor, "R2 crc verdict", {79'd0, crc_ok}, {79'd0, !cor});
      chk(ready_n == !good, "R3 ready", {79'd0, ready_n}, {79'd0, !good});
      if (good) last_good = d;
      host_read(8'h02, !good, last_good, 0, "R1 R5 readout");
    end

    // R4: block start raises ready
    send_block(80'h1111_2222_3333_4444_5555, 0, 0);
    chk(ready_n == 0, "R4 ready before start", {79'd0, ready_n}, 80'd0);
    sync0 = 1; tick(); sync0 = 0;
    chk(ready_n == 1, "R4 ready after sync0", {79'd0, ready_n}, 80'd1);
    tick();

    // R5: aborted partial block keeps buffer, then new good block
    last_good = 80'h1111_2222_3333_4444_5555;
    sync1 = 1; tick(); sync1 = 0; tick();
    push_bits({80'hFFFF_0000_FFFF_0000_FFFF, 16'h0}, 50);
    host_read(8'h02, 1'b1, last_good, 0, "R5 partial keeps buffer");
    send_block(80'h0F0F_1E1E_2D2D_3C3C_4B4B, 0, 0);
    last_good = 80'h0F0F_1E1E_2D2D_3C3C_4B4B;
    chk(ready_n == 0, "R5 restart validates", {79'd0, ready_n}, 80'd0);

    // R9: extra strobes ignored
    push_bits({96{1'b1}}, 6);
    chk(ready_n == 0 && crc_ok == 1, "R9 extra strobes", {78'd0, ready_n, crc_ok},
        {78'd0, 2'b01});
    host_read(8'hF2, 1'b0, last_good, 0, "R9 R6 upper bits ignored");

    // R5: read not disturbed by new accumulation
    send_block(80'h7E57_0001_0203_0405_0607, 0, 0);
    last_good = 80'h7E57_0001_0203_0405_0607;
    host_read(8'h02, 1'b0, last_good, 1, "R5 read during accumulation");

    // R8: foreign command
    host_cmd(8'h03);
    for (int i = 0; i < 3; i++) begin hck = 1; tick(); hck = 0; tick(); end
    chk(sdo_oe == 0 && sdo == 0, "R8 foreign code", {78'd0, sdo_oe, sdo}, 80'd0);
    hlat = 1; tick();

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule